// File: doc/BRIEF.md
# Host Interrupt Aggregation Controller

This block gathers single-cycle event pulses from up to sixteen internal sources into a sticky status vector. It combines that vector with a host mask to drive one registered interrupt line towards the host. Software reaches it over a small synchronous register bus with an address, a write strobe with data, and a read strobe. Read data comes back one cycle after the read strobe.

The mask can be written whole, or changed bit by bit through a write-one-to-set alias and a write-one-to-clear alias. Status can be read in two ways: a peek that leaves it alone, and a pop that returns it and then empties it. Individual bits can also be retired by a write-one acknowledge. An event that arrives in the same cycle as a clear of its own bit always wins, so no event is dropped.

Top module: `hostIrqAgg`

## Requirements
- R1: After reset the mask reads 0x0001, status reads 0, `irqOut` is low and `busRdData` is 0.
- R2: A write to offset 0 loads the whole mask. A read of offset 0 returns the mask in the next cycle.
- R3: A write to offset 1 sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: A write to offset 2 clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: A pulse on `evtIn[i]` sets status bit i, whether or not that bit is masked. A read of offset 3 returns status and leaves it unchanged.
- R6: A read of offset 4 returns status in the next cycle and clears every status bit.
- R7: A write to offset 5 clears each status bit whose data bit is 1. Data bits that are 0 leave status unchanged.
- R8: An event pulse in the same cycle as a clear of its bit, by acknowledge or by pop, leaves that bit set.
- R9: `irqOut` is high exactly one cycle after a cycle in which some status bit is set and its mask bit is 0. A mask bit of 1 blocks the matching source.
- R10: Reads of offsets 1, 2, 5 and unmapped offsets (6, 7) return 0. Writes to offsets 3, 4, 6 and 7 change neither mask nor status. `busRdData` is 0 in any cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | NUM_SRC | Single-cycle event pulses, one per source |
| busAddr | input | ADDR_W | Register offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | NUM_SRC | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | NUM_SRC | Read data, valid one cycle after the read strobe |
| irqOut | output | 1 | Registered host interrupt, active high |

## Verification
The risky overlap is an event pulse landing in the same cycle as a clear of the same status bit, either through a pop read or through an acknowledge write. The bench provokes this on purpose by pulsing chosen sources in the very cycle of the pop and of the acknowledge. A long stretch of random traffic then mixes events, reads and writes freely. A behavioural reference model decides, clock by clock, whether the bit survives, and compares read data and the interrupt line against the design on every cycle.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

  // Register offsets; the bench and software rely on these values.
  localparam int unsigned OFF_MASK     = 0;
  localparam int unsigned OFF_MASK_SET = 1;
  localparam int unsigned OFF_MASK_CLR = 2;
  localparam int unsigned OFF_PEEK     = 3;
  localparam int unsigned OFF_POP      = 4;
  localparam int unsigned OFF_ACK      = 5;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic wrMask;
    logic setMask;
    logic clrMask;
    logic ackStat;
    logic rdMask;
    logic peekStat;
    logic popStat;
  } hirqStrobe_t;

endpackage

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
  import hirq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output hirqStrobe_t       stb
);

  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_MASK_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_MASK_CLR);
  localparam logic [ADDR_W-1:0] A_PEEK = ADDR_W'(OFF_PEEK);
  localparam logic [ADDR_W-1:0] A_POP  = ADDR_W'(OFF_POP);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFF_ACK);

  always_comb begin
    stb          = '0;
    stb.wrMask   = busWrEn && (busAddr == A_MASK);
    stb.setMask  = busWrEn && (busAddr == A_SET);
    stb.clrMask  = busWrEn && (busAddr == A_CLR);
    stb.ackStat  = busWrEn && (busAddr == A_ACK);
    stb.rdMask   = busRdEn && (busAddr == A_MASK);
    stb.peekStat = busRdEn && (busAddr == A_PEEK);
    stb.popStat  = busRdEn && (busAddr == A_POP);
  end

endmodule

// File: rtl/hirq_datapath.sv
module hirq_datapath
  import hirq_pkg::*;
#(
  parameter int                 NUM_SRC  = 16,
  parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  hirqStrobe_t        stb,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] pending;

  // Bits retired this cycle: acknowledge data, or all bits on a pop.
  always_comb begin
    clrVec = '0;
    if (stb.ackStat) clrVec = clrVec | wrData;
    if (stb.popStat) clrVec = '1;
  end

  // Sticky status; an event beats a clear of the same bit.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) status[i] <= 1'b0;
      else       status[i] <= evtIn[i] | (status[i] & ~clrVec[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask <= MASK_RST;
    end else if (stb.wrMask) begin
      mask <= wrData;
    end else if (stb.setMask) begin
      mask <= mask | wrData;
    end else if (stb.clrMask) begin
      mask <= mask & ~wrData;
    end
  end

  assign pending = status & ~mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      rdData <= '0;
    end else begin
      irqOut <= |pending;
      if (stb.peekStat || stb.popStat) rdData <= status;
      else if (stb.rdMask)             rdData <= mask;
      else                             rdData <= '0;
    end
  end

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((status & $past(evtIn)) == $past(evtIn))); // R8

  AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.popStat && evtIn == '0) |=> (status == '0)); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackStat && !stb.popStat && evtIn == '0)
      |=> ((status & $past(wrData)) == '0)); // R7

  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.peekStat && !stb.ackStat && evtIn == '0) |=> $stable(status)); // R5

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.setMask |=> ((mask & $past(wrData)) == $past(wrData))); // R3

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrMask |=> ((mask & $past(wrData)) == '0)); // R4

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~mask) == '0) |=> !irqOut); // R9

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~mask) != '0) |=> irqOut); // R9

endmodule

// File: rtl/hostIrqAgg.sv
module hostIrqAgg
  import hirq_pkg::*;
#(
  parameter int                 NUM_SRC  = 16,
  parameter int                 ADDR_W   = 3,
  parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] busWrData,
  input  logic               busRdEn,
  output logic [NUM_SRC-1:0] busRdData,
  output logic               irqOut
);

  hirqStrobe_t stb;

  hirq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .stb     (stb)
  );

  hirq_datapath #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_RST)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (busWrData),
    .evtIn  (evtIn),
    .rdData (busRdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/hostIrqAgg_tb.sv
`timescale 1ns/1ps
module hostIrqAgg_tb;

  localparam int NS = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] evtIn = '0;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [NS-1:0] busWrData = '0;
  logic          busRdEn = 1'b0;
  logic [NS-1:0] busRdData;
  logic          irqOut;

  always #4 clk = ~clk; // 125 MHz

  hostIrqAgg u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  int    nRun = 0;
  int    nFail = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  // Behavioural reference model
  logic [NS-1:0] mMask, mStat, mRd;
  logic          mIrq;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask = 16'h0001; mStat = '0; mRd = '0; mIrq = 1'b0;
    end else begin
      logic [NS-1:0] nextStat;
      mIrq = (mStat & ~mMask) != 0;
      mRd = '0;
      if (busRdEn) begin
        if (busAddr == 0) mRd = mMask;
        else if (busAddr == 3 || busAddr == 4) mRd = mStat;
      end
      nextStat = mStat;
      if (busRdEn && busAddr == 4) nextStat = '0;
      if (busWrEn && busAddr == 5) nextStat = nextStat & ~busWrData;
      nextStat = nextStat | evtIn;
      mStat = nextStat;
      if (busWrEn) begin
        if (busAddr == 0) mMask = busWrData;
        else if (busAddr == 1) mMask = mMask | busWrData;
        else if (busAddr == 2) mMask = mMask & ~busWrData;
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      nRun++;
      if (busRdData !== mRd || irqOut !== mIrq) begin
        nFail++;
        $display("FAIL %s cycle %0d: rdData=%h irq=%b expected rdData=%h irq=%b",
                 curReq, cycles, busRdData, irqOut, mRd, mIrq);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busWrEn = 0; busRdEn = 0; evtIn = '0;
    end
  endtask

  task automatic cyc(input bit we, input bit re, input int addr,
                     input logic [NS-1:0] d, input logic [NS-1:0] ev);
    @(negedge clk);
    busWrEn = we; busRdEn = re; busAddr = AW'(addr); busWrData = d; evtIn = ev;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    nRun++;
    if (busRdData !== 0 || irqOut !== 0) begin
      nFail++;
      $display("FAIL R1 reset outputs: rdData=%h irq=%b expected 0 0", busRdData, irqOut);
    end
    rstN = 1'b1;
    cyc(0, 1, 0, 0, 0); idle(2);                 // R1 mask reads 0x0001
    cyc(0, 1, 3, 0, 0); idle(2);

    curReq = "R2";
    cyc(1, 0, 0, 16'hA5A5, 0); cyc(0, 1, 0, 0, 0); idle(2);
    curReq = "R3";
    cyc(1, 0, 1, 16'h0F00, 0); cyc(0, 1, 0, 0, 0); idle(2);
    curReq = "R4";
    cyc(1, 0, 2, 16'h00F5, 0); cyc(0, 1, 0, 0, 0); idle(2);

    curReq = "R9";                               // all masked: no irq
    cyc(1, 0, 0, 16'hFFFF, 0);
    curReq = "R5";
    cyc(0, 0, 0, 0, 16'h8001); cyc(0, 0, 0, 0, 16'h0240); idle(3);
    cyc(0, 1, 3, 0, 0); cyc(0, 1, 3, 0, 0); idle(2);
    curReq = "R9";
    cyc(1, 0, 2, 16'h0040, 0); idle(3);          // unmask bit 6
    cyc(1, 0, 1, 16'h0040, 0); idle(3);

    curReq = "R6";
    cyc(0, 1, 4, 0, 0); cyc(0, 1, 3, 0, 0); idle(2);

    curReq = "R7";
    cyc(1, 0, 0, 16'h0000, 16'h00FF); idle(2);
    cyc(1, 0, 5, 16'h000F, 0); cyc(0, 1, 3, 0, 0);
    cyc(1, 0, 5, 16'h0000, 0); cyc(0, 1, 3, 0, 0); idle(2);

    curReq = "R8";                               // event collides with clear
    cyc(1, 0, 5, 16'h00F0, 16'h0010); cyc(0, 1, 3, 0, 0);
    cyc(0, 1, 4, 0, 16'h0300); cyc(0, 1, 3, 0, 0);
    cyc(1, 1, 5, 16'hFFFF, 16'h4000); cyc(0, 1, 3, 0, 0); idle(3);

    curReq = "R10";
    cyc(0, 0, 0, 0, 16'h1234); idle(1);
    cyc(0, 1, 1, 0, 0); cyc(0, 1, 2, 0, 0); cyc(0, 1, 5, 0, 0);
    cyc(0, 1, 6, 0, 0); cyc(0, 1, 7, 0, 0);
    cyc(1, 0, 3, 16'hFFFF, 0); cyc(1, 0, 4, 16'hFFFF, 0);
    cyc(1, 0, 6, 16'hFFFF, 0); cyc(1, 0, 7, 16'hFFFF, 0);
    cyc(0, 1, 3, 0, 0); cyc(0, 1, 0, 0, 0); idle(2);

    curReq = "R8";                               // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[1], int'(r[4:2]), NS'($urandom),
          (r[7:5] == 0) ? NS'($urandom) : NS'(0));
    end
    idle(3);
    done = 1'b1;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    nRun++; nFail++;
    done = 1'b1;
    $display("FAIL watchdog: run did not complete, actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule